// File: doc/BRIEF.md
# Serial SAD Engine with Early Termination

This block scores one candidate block of a motion search against the current macroblock. After a start pulse it accepts 256 pixel pairs (16 rows of 16 pixels), one pair per clock, and adds the absolute difference of each pair into a running total. The running total is held as two vectors, a sum vector and a carry vector, so the accumulation loop has no carry-propagate adder. The two vectors are resolved into a binary value only outside the loop, where the result is reported and compared.

A best-match comparator watches the running total against the lowest total seen so far. As soon as the partial total reaches or passes that best value, the candidate cannot win. The engine then stops, reports the candidate as aborted, and blocks any further accumulation. A candidate that completes all 256 pairs with a strictly lower total replaces the stored best total and the stored best motion vector.

A search controller pulses the clear-best input at the start of each macroblock, then runs one start/stream/done sequence per candidate. At the end it reads the winning vector.

Top module: `serial_sad_engine`

## Requirements
- R1: After reset, busy, done and aborted are 0, best_sad is all ones (65535) and best_mv is 0.
- R2: A clear_best pulse while idle sets best_sad to all ones and best_mv to 0 from the next cycle on.
- R3: A start pulse while idle latches cand_mv, zeroes the running total, and raises busy from the next cycle. busy stays high until the cycle in which done is seen.
- R4: During a candidate, a pixel pair counts only on a clock where pix_valid is 1. Pixel values on other clocks have no effect on cand_sad.
- R5: A candidate that is never stopped early takes exactly 256 accepted pairs. done rises one cycle after the clock that accepts the last pair, and cand_sad then equals the sum of |cur_pix - ref_pix| over those pairs, with pixels as 8-bit unsigned values.
- R6: On any clock of a candidate where the total of the pairs accepted so far is greater than or equal to best_sad, the candidate ends at that edge. The pair offered on that clock is not accepted, done and aborted read 1 after the edge, and cand_sad holds the partial total.
- R7: A candidate whose full total is below best_sad sets best_sad to that total and best_mv to its latched cand_mv. These appear in the same cycle as done, with aborted 0.
- R8: A full total equal to best_sad is reported as aborted, and best_sad and best_mv keep their earlier values, so the first of equal candidates wins.
- R9: done is high for exactly one cycle per candidate.
- R10: best_sad never increases except through clear_best.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_best | input | 1 | Load the best total with all ones and clear the best vector |
| start | input | 1 | Begin a new candidate (accepted when idle) |
| cand_mv | input | MV_W (16) | Motion vector tag of the candidate being started |
| pix_valid | input | 1 | A pixel pair is presented on this clock |
| cur_pix | input | PIX_W (8) | Pixel of the current macroblock |
| ref_pix | input | PIX_W (8) | Pixel of the candidate block |
| busy | output | 1 | A candidate is in progress |
| done | output | 1 | One-cycle pulse at the end of a candidate |
| aborted | output | 1 | The last candidate was stopped or did not beat the best total |
| cand_sad | output | ACC_W (16) | Resolved total of the last candidate (partial if aborted) |
| best_sad | output | ACC_W (16) | Lowest complete total since the last clear |
| best_mv | output | MV_W (16) | Vector tag of the candidate that holds best_sad |

## Verification
The assertions assume that clear_best and start arrive only while busy is low, and never on the same clock. They also assume a caller never pulses start again before done has been seen. The stimulus issues each clear and each start from the idle state and waits for done before going on. The bench model predicts the exact pair index at which each candidate stops, so early stops, ties and full completions are all checked against those timing assumptions. Pixel-valid gaps are filled with maximum-difference garbage, so any pixel that is wrongly accepted shows up in cand_sad.

// File: rtl/sad_pkg.sv
// Package: shared types of the serial SAD engine.
// Assumes: nothing; holds the controller state encoding only.
package sad_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCUM  = 2'd1,
        ST_FINISH = 2'd2
    } sad_state_e;
endpackage

// File: rtl/sad_absdiff.sv
// Module: absolute difference of two unsigned pixels, with operand isolation.
// Assumes: both pixels are unsigned; when en is low the output is forced to
// zero so the downstream adder sees no switching.
module sad_absdiff #(
    parameter int PIX_W = 8
) (
    input  logic             en,
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    output logic [PIX_W-1:0] d
);
    // Purpose: pick the non-negative difference, or zero when disabled.
    always_comb begin
        if (!en)
            d = '0;
        else if (a >= b)
            d = a - b;
        else
            d = b - a;
    end
endmodule

// File: rtl/sad_csa_acc.sv
// Module: carry-save accumulator for the running distortion total.
// Assumes: clr and en are never high together; the full total fits in ACC_W
// bits, so the carry leaving the top bit is always zero and is dropped.
module sad_csa_acc #(
    parameter int PIX_W = 8,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PIX_W-1:0] din,
    output logic [ACC_W-1:0] total
);
    localparam int PAD_W = ACC_W - PIX_W;

    logic [ACC_W-1:0] s_q;
    logic [ACC_W-1:0] c_q;
    logic [ACC_W-1:0] d_ext;

    assign d_ext = {{PAD_W{1'b0}}, din};

    // Purpose: 3:2 compression of sum, carry and new term; no carry ripple.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            s_q <= '0;
            c_q <= '0;
        end else if (en) begin
            s_q <= s_q ^ c_q ^ d_ext;
            c_q <= {(s_q[ACC_W-2:0] & c_q[ACC_W-2:0]) |
                    (s_q[ACC_W-2:0] & d_ext[ACC_W-2:0]) |
                    (c_q[ACC_W-2:0] & d_ext[ACC_W-2:0]), 1'b0};
        end
    end

    // Purpose: resolve the redundant pair; this adder sits outside the loop.
    always_comb total = s_q + c_q;

    // R5
    acc_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> (total >= $past(total)));
endmodule

// File: rtl/sad_best_match.sv
// Module: best-total store and zero-latency greater-or-equal detector.
// Assumes: upd is raised only for a total below the stored best and never
// together with clear_best.
module sad_best_match #(
    parameter int ACC_W = 16,
    parameter int MV_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_best,
    input  logic [ACC_W-1:0] partial,
    input  logic             upd,
    input  logic [MV_W-1:0]  upd_mv,
    output logic             ge,
    output logic [ACC_W-1:0] best_sad,
    output logic [MV_W-1:0]  best_mv
);
    // Purpose: combinational compare of the running total with the best.
    always_comb ge = (partial >= best_sad);

    // Purpose: hold the winning total and vector; clear at each macroblock.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_best) begin
            best_sad <= '1;
            best_mv  <= '0;
        end else if (upd) begin
            best_sad <= partial;
            best_mv  <= upd_mv;
        end
    end

    // R10
    best_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_best |=> (best_sad <= $past(best_sad)));

    // R7
    upd_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> (partial < best_sad));
endmodule

// File: rtl/serial_sad_engine.sv
// Module: serial SAD engine top; one pixel pair per clock, early abort.
// Assumes: start and clear_best come only while idle and not together; a
// candidate is ROWS rows of ROW_PIX pixels, presented under pix_valid.
module serial_sad_engine #(
    parameter int PIX_W   = 8,
    parameter int ROW_PIX = 16,
    parameter int ROWS    = 16,
    parameter int MV_W    = 16
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        clear_best,
    input  logic                                        start,
    input  logic [MV_W-1:0]                             cand_mv,
    input  logic                                        pix_valid,
    input  logic [PIX_W-1:0]                            cur_pix,
    input  logic [PIX_W-1:0]                            ref_pix,
    output logic                                        busy,
    output logic                                        done,
    output logic                                        aborted,
    output logic [PIX_W+$clog2(ROW_PIX*ROWS)-1:0]       cand_sad,
    output logic [PIX_W+$clog2(ROW_PIX*ROWS)-1:0]       best_sad,
    output logic [MV_W-1:0]                             best_mv
);
    import sad_pkg::*;

    localparam int PAIRS = ROW_PIX * ROWS;
    localparam int CNT_W = $clog2(PAIRS);
    localparam int ACC_W = PIX_W + CNT_W;
    localparam int COL_W = $clog2(ROW_PIX);
    localparam int ROW_W = $clog2(ROWS);

    sad_state_e        state;
    logic [COL_W-1:0]  col_q;
    logic [ROW_W-1:0]  row_q;
    logic [MV_W-1:0]   mv_q;
    logic              ge;
    logic              acc_en;
    logic              acc_clr;
    logic              upd;
    logic              last_pair;
    logic [PIX_W-1:0]  diff;
    logic [ACC_W-1:0]  total;

    // Purpose: decode the enables of the arithmetic from the controller.
    always_comb begin
        acc_en    = (state == ST_ACCUM) && pix_valid && !ge;
        acc_clr   = (state == ST_IDLE) && start;
        upd       = (state == ST_FINISH) && !ge;
        last_pair = (col_q == COL_W'(ROW_PIX - 1)) && (row_q == ROW_W'(ROWS - 1));
        busy      = (state != ST_IDLE);
    end

    sad_absdiff #(.PIX_W(PIX_W)) i_absdiff (
        .en (acc_en),
        .a  (cur_pix),
        .b  (ref_pix),
        .d  (diff)
    );

    sad_csa_acc #(.PIX_W(PIX_W), .ACC_W(ACC_W)) i_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (acc_en),
        .din   (diff),
        .total (total)
    );

    sad_best_match #(.ACC_W(ACC_W), .MV_W(MV_W)) i_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_best (clear_best),
        .partial    (total),
        .upd        (upd),
        .upd_mv     (mv_q),
        .ge         (ge),
        .best_sad   (best_sad),
        .best_mv    (best_mv)
    );

    // Purpose: sequence a candidate through accumulate, abort or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            col_q    <= '0;
            row_q    <= '0;
            mv_q     <= '0;
            done     <= 1'b0;
            aborted  <= 1'b0;
            cand_sad <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_ACCUM;
                        mv_q    <= cand_mv;
                        col_q   <= '0;
                        row_q   <= '0;
                        aborted <= 1'b0;
                    end
                end
                ST_ACCUM: begin
                    if (ge) begin
                        state    <= ST_IDLE;
                        done     <= 1'b1;
                        aborted  <= 1'b1;
                        cand_sad <= total;
                    end else if (pix_valid) begin
                        if (last_pair) begin
                            state <= ST_FINISH;
                        end else if (col_q == COL_W'(ROW_PIX - 1)) begin
                            col_q <= '0;
                            row_q <= row_q + 1'b1;
                        end else begin
                            col_q <= col_q + 1'b1;
                        end
                    end
                end
                ST_FINISH: begin
                    state    <= ST_IDLE;
                    done     <= 1'b1;
                    cand_sad <= total;
                    aborted  <= ge;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM && ge) |=> (done && aborted && !busy));

    // R7
    win_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !aborted) |-> (best_sad == cand_sad));

    // R8
    loss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && aborted && !$past(clear_best)) |-> ($stable(best_sad) && $stable(best_mv)));
endmodule

// File: tb/test_serial_sad_engine.sv
module test_serial_sad_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_best = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cand_mv = '0;
    logic        pix_valid = 1'b0;
    logic [7:0]  cur_pix = '0;
    logic [7:0]  ref_pix = '0;
    logic        busy, done, aborted;
    logic [15:0] cand_sad, best_sad, best_mv;

    int total_chk = 0;
    int bad = 0;
    int m_best = 65535;
    int m_mv = 0;

    always #4 clk = ~clk;

    serial_sad_engine i_serial_sad_engine (
        .clk(clk), .rst_n(rst_n), .clear_best(clear_best), .start(start),
        .cand_mv(cand_mv), .pix_valid(pix_valid), .cur_pix(cur_pix),
        .ref_pix(ref_pix), .busy(busy), .done(done), .aborted(aborted),
        .cand_sad(cand_sad), .best_sad(best_sad), .best_mv(best_mv)
    );

    task automatic chk(input string req, input int act, input int exp);
        total_chk++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int pc(input int k, input int i);
        if (k == 100) return 255;
        return (i * 7 + k * 29 + (i >> 4) * k) % 256;
    endfunction

    function automatic int pr(input int k, input int i);
        if (k == 100) return 0;
        if (k == 101) return pc(k, i);
        return (i * 5 + k * k * 3 + (i % 16) * k) % 256;
    endfunction

    function automatic int ad(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic do_clear();
        @(negedge clk);
        clear_best = 1'b1;
        @(negedge clk);
        clear_best = 1'b0;
        m_best = 65535;
        m_mv = 0;
        chk("R2 best_sad", int'(best_sad), 65535);
        chk("R2 best_mv", int'(best_mv), 0);
    endtask

    task automatic run_cand(input int k, input int mv, input bit gaps);
        int p = 0;
        int exp_at = -1;
        int exp_sad = 0;
        int got_at = -1;
        bit exp_ab;
        for (int i = 0; i < 256; i++) begin
            if (exp_at < 0 && p >= m_best) begin
                exp_at = i;
                exp_sad = p;
            end
            p += ad(pc(k, i), pr(k, i));
        end
        if (exp_at < 0) begin
            exp_at = 256;
            exp_sad = p;
        end
        exp_ab = (exp_sad >= m_best);
        @(negedge clk);
        start = 1'b1;
        cand_mv = mv[15:0];
        @(negedge clk);
        start = 1'b0;
        chk("R3 busy after start", int'(busy), 1);
        for (int i = 0; i < 256; i++) begin
            if (gaps && (i % 3 == 1)) begin
                pix_valid = 1'b0;
                cur_pix = 8'hff;
                ref_pix = 8'h00;
                @(negedge clk);
                if (done) begin got_at = i; break; end
            end
            pix_valid = 1'b1;
            cur_pix = pc(k, i);
            ref_pix = pr(k, i);
            @(negedge clk);
            pix_valid = 1'b0;
            cur_pix = 8'hff;
            ref_pix = 8'h00;
            if (done) begin got_at = i; break; end
        end
        if (got_at < 0) begin
            @(negedge clk);
            chk("R5 done one cycle after last pair", int'(done), 1);
            got_at = 256;
        end
        chk("R6 stop index", got_at, exp_at);
        chk(gaps ? "R4 cand_sad with gaps" : "R5 cand_sad", int'(cand_sad), exp_sad);
        chk("R8 aborted flag", int'(aborted), int'(exp_ab));
        if (!exp_ab) begin
            m_best = exp_sad;
            m_mv = mv;
        end
        chk("R7 best_sad", int'(best_sad), m_best);
        chk("R7 best_mv", int'(best_mv), m_mv);
        @(negedge clk);
        chk("R9 done one cycle", int'(done), 0);
        chk("R3 busy low after done", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 aborted", int'(aborted), 0);
        chk("R1 best_sad", int'(best_sad), 65535);
        chk("R1 best_mv", int'(best_mv), 0);
        do_clear();
        run_cand(100, 16'h0101, 1'b0);   // R5 maximum total 65280
        for (int k = 1; k <= 12; k++)
            run_cand(k, 16'h0200 + k, (k % 2) == 0);
        run_cand(101, 16'h0a0b, 1'b1);   // R7 zero total wins
        run_cand(5, 16'h0c0d, 1'b0);     // R6 stop at first clock
        do_clear();
        run_cand(3, 16'h1111, 1'b0);
        run_cand(3, 16'h2222, 1'b1);     // R8 tie keeps first vector
        run_cand(7, 16'h3333, 1'b0);
        $display("  test done: total=%0d bad=%0d", total_chk, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total_chk++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total_chk, bad);
        $finish;
    end
endmodule